// File: doc/BRIEF.md
# SPI Flash Opcode Dispatch Parser

This block sits behind the byte deserializer of an SPI device that emulates a serial flash. It looks at the first byte of each transaction and compares it with a table of programmable command slots. Each slot holds a valid bit, an opcode, an upload flag and a read pipeline mode. From the result it selects exactly one downstream datapath, or none. The choices are status read, identification read, discoverable-parameter read, normal read, upload, 4-byte address enter or exit, and write enable or disable. It also keeps the matched slot's fields for the rest of the transaction.

Some slot positions carry a fixed meaning, because the datapath a command reaches depends on where it sits in the table. Slots 0 to 2 are status reads. Slot 3 is the identification read and slot 4 the parameter read. Slots 5 and 6 enter and exit 4-byte addressing. Slots 7 and 8 enable and disable writes. All slots from 9 upward are general read or upload commands.

The block has a synchronous active-high reset. That reset stands for chip-select deassertion, so it is pulsed between transactions. After one decode the block holds its result until the next reset.

Top module: `spi_op_router`

## Requirements
- R1: During and right after reset, `path_sel_o` is 0, `path_sub_o` is 0 and all latched info outputs are 0.
- R2: The parser is active only when `spi_mode_i` is 1 (flash) or 2 (passthrough). In modes 0 and 3, valid bytes leave every output unchanged. A later byte in an active mode is still decoded as the first byte.
- R3: Only the first valid byte after reset is decoded. The result appears on the outputs after the clock edge that samples the byte. All later bytes leave select and info unchanged until the next reset.
- R4: Slot i occupies `slot_cfg_i[i*12 +: 12]` as {valid[11], opcode[10:3], upload[2], pipe[1:0]}. A slot is eligible when valid is 1, its opcode equals the byte and it is not busy-gated. The lowest-index eligible slot wins.
- R5: Slots 0 to 2 select bit 0 (status), slot 3 selects bit 1 (identification) and slot 4 selects bit 2 (parameter). In flash mode these are always selected. In passthrough mode each is selected only when its intercept enable is 1; otherwise the select is 0.
- R6: Slots 5 and 6 select bit 5, with `path_sub_o` 1 for slot 5 (enter) and 0 for slot 6 (exit). Slots 7 and 8 select bit 6, with `path_sub_o` 1 for slot 7 (enable) and 0 for slot 8 (disable). Slots 5 to 8 are not eligible while `busy_i` is 1.
- R7: A slot from 9 upward selects bit 4 (upload) when its upload flag is 1, and bit 3 (read) otherwise. An upload-flagged slot is not eligible while `busy_i` is 1.
- R8: When no slot is eligible, the select is 0 and the latched info is 0.
- R9: The info outputs are the winning slot's fields, latched at decode. `info_two_stage_o` is 1 when the latched pipe is 1 (half-cycle two-stage) or 2 (full-cycle two-stage).
- R10: At most one bit of `path_sel_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset (chip-select deasserted) |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | Byte strobe, one cycle per byte |
| spi_mode_i | input | 2 | 1 flash, 2 passthrough, others inactive |
| busy_i | input | 1 | Device busy status bit |
| icpt_status_i | input | 1 | Passthrough intercept enable for status reads |
| icpt_ident_i | input | 1 | Passthrough intercept enable for identification read |
| icpt_param_i | input | 1 | Passthrough intercept enable for parameter read |
| slot_cfg_i | input | NUM_SLOTS*12 | Packed command slot table |
| path_sel_o | output | 7 | One-hot datapath select, 0 for none |
| path_sub_o | output | 1 | Enter/exit or enable/disable sub-select |
| info_vld_o | output | 1 | Latched slot valid bit |
| info_opcode_o | output | 8 | Latched slot opcode |
| info_upload_o | output | 1 | Latched slot upload flag |
| info_pipe_o | output | 2 | Latched slot pipeline mode |
| info_two_stage_o | output | 1 | Latched pipeline is a two-stage mode |

## Verification
Some properties are checked on every cycle. The select is never more than one-hot. A select bit can only rise after a valid byte seen in an active mode. Once the parser leaves idle, the select and the latched info stay frozen. In an inactive mode the parser stays idle. The select is 0 whenever the parser is idle or waiting. The routing itself can only be shown by the bench's scenarios: which slot wins among colliding opcodes, how busy gating works, intercept behaviour in passthrough mode, the sub-select polarity and the two-stage flag. The bench compares each decode against its own model of the slot rules.

// File: rtl/op_router_pkg.sv
package op_router_pkg;
  localparam int OPC_W   = 8;
  localparam int PIPE_W  = 2;
  localparam int SLOT_W  = OPC_W + PIPE_W + 2;
  localparam int PATH_N  = 7;

  // fixed slot positions
  localparam int SLOT_JEDEC = 3;
  localparam int SLOT_PARAM = 4;
  localparam int SLOT_EN4B  = 5;
  localparam int SLOT_EX4B  = 6;
  localparam int SLOT_WREN  = 7;
  localparam int SLOT_WRDI  = 8;
  localparam int GEN_BASE   = 9;

  // select bit positions
  localparam int P_STATUS = 0;
  localparam int P_IDENT  = 1;
  localparam int P_PARAM  = 2;
  localparam int P_READ   = 3;
  localparam int P_UPLOAD = 4;
  localparam int P_ADDR4B = 5;
  localparam int P_WREN   = 6;

  localparam logic [1:0] MODE_FLASH = 2'd1;
  localparam logic [1:0] MODE_PASS  = 2'd2;
  localparam logic [1:0] PIPE_HALF  = 2'd1;
  localparam logic [1:0] PIPE_FULL  = 2'd2;

  typedef struct packed {
    logic              vld;
    logic [OPC_W-1:0]  opc;
    logic              upl;
    logic [PIPE_W-1:0] pipe;
  } slot_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STATUS, ST_IDENT, ST_PARAM, ST_READ,
    ST_UPLOAD, ST_ADDR4B, ST_WREN, ST_WAIT
  } state_e;
endpackage

// File: rtl/op_slot_matcher.sv
module op_slot_matcher
  import op_router_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  slot_t [NUM_SLOTS-1:0] slots_i,
  input  logic [OPC_W-1:0]      byte_i,
  input  logic                  busy_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o,
  output slot_t                 info_o
);
  logic [NUM_SLOTS-1:0] elig;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam bit FIXED_GATE = (g >= SLOT_EN4B) && (g <= SLOT_WRDI);
    localparam bit GENERAL    = (g >= GEN_BASE);
    logic gated;
    assign gated    = FIXED_GATE || (GENERAL && slots_i[g].upl);
    assign elig[g]  = slots_i[g].vld && (slots_i[g].opc == byte_i) && !(gated && busy_i);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    info_o = hit_o ? slots_i[idx_o] : '0;
  end
endmodule

// File: rtl/op_route_decide.sv
module op_route_decide
  import op_router_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              upl_i,
  input  logic              flash_i,
  input  logic              icpt_status_i,
  input  logic              icpt_ident_i,
  input  logic              icpt_param_i,
  output state_e            nxt_o,
  output logic [PATH_N-1:0] sel_o,
  output logic              sub_o
);
  int k;
  assign k = int'(idx_i);

  always_comb begin
    nxt_o = ST_WAIT;
    sel_o = '0;
    sub_o = 1'b0;
    if (hit_i) begin
      if (k < SLOT_JEDEC) begin
        if (flash_i || icpt_status_i) begin
          nxt_o = ST_STATUS; sel_o[P_STATUS] = 1'b1;
        end
      end else if (k == SLOT_JEDEC) begin
        if (flash_i || icpt_ident_i) begin
          nxt_o = ST_IDENT; sel_o[P_IDENT] = 1'b1;
        end
      end else if (k == SLOT_PARAM) begin
        if (flash_i || icpt_param_i) begin
          nxt_o = ST_PARAM; sel_o[P_PARAM] = 1'b1;
        end
      end else if (k == SLOT_EN4B || k == SLOT_EX4B) begin
        nxt_o = ST_ADDR4B; sel_o[P_ADDR4B] = 1'b1;
        sub_o = (k == SLOT_EN4B);
      end else if (k == SLOT_WREN || k == SLOT_WRDI) begin
        nxt_o = ST_WREN; sel_o[P_WREN] = 1'b1;
        sub_o = (k == SLOT_WREN);
      end else if (upl_i) begin
        nxt_o = ST_UPLOAD; sel_o[P_UPLOAD] = 1'b1;
      end else begin
        nxt_o = ST_READ; sel_o[P_READ] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_op_router.sv
module spi_op_router
  import op_router_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [OPC_W-1:0]            byte_i,
  input  logic                        byte_vld_i,
  input  logic [1:0]                  spi_mode_i,
  input  logic                        busy_i,
  input  logic                        icpt_status_i,
  input  logic                        icpt_ident_i,
  input  logic                        icpt_param_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] slot_cfg_i,
  output logic [PATH_N-1:0]           path_sel_o,
  output logic                        path_sub_o,
  output logic                        info_vld_o,
  output logic [OPC_W-1:0]            info_opcode_o,
  output logic                        info_upload_o,
  output logic [PIPE_W-1:0]           info_pipe_o,
  output logic                        info_two_stage_o
);
  slot_t [NUM_SLOTS-1:0] slots;
  assign slots = slot_cfg_i;

  logic             hit;
  logic [IDX_W-1:0] idx;
  slot_t            match_info;
  state_e           nxt;
  logic [PATH_N-1:0] nxt_sel;
  logic             nxt_sub;

  state_e state_q;
  slot_t  info_q;

  logic active, flash, decode_en;
  assign flash     = (spi_mode_i == MODE_FLASH);
  assign active    = flash || (spi_mode_i == MODE_PASS);
  assign decode_en = (state_q == ST_IDLE) && active && byte_vld_i;

  op_slot_matcher #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .slots_i(slots), .byte_i(byte_i), .busy_i(busy_i),
    .hit_o(hit), .idx_o(idx), .info_o(match_info)
  );

  op_route_decide #(.NUM_SLOTS(NUM_SLOTS)) u_route (
    .hit_i(hit), .idx_i(idx), .upl_i(match_info.upl), .flash_i(flash),
    .icpt_status_i(icpt_status_i), .icpt_ident_i(icpt_ident_i),
    .icpt_param_i(icpt_param_i),
    .nxt_o(nxt), .sel_o(nxt_sel), .sub_o(nxt_sub)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ST_IDLE;
      path_sel_o <= '0;
      path_sub_o <= 1'b0;
      info_q     <= '0;
    end else if (decode_en) begin
      state_q    <= nxt;
      path_sel_o <= nxt_sel;
      path_sub_o <= nxt_sub;
      info_q     <= match_info;
    end
  end

  assign info_vld_o       = info_q.vld;
  assign info_opcode_o    = info_q.opc;
  assign info_upload_o    = info_q.upl;
  assign info_pipe_o      = info_q.pipe;
  assign info_two_stage_o = (info_q.pipe == PIPE_HALF) || (info_q.pipe == PIPE_FULL);

  // R10
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(path_sel_o));

  // R2
  sel_rise_needs_byte_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(|path_sel_o) |-> $past(byte_vld_i && active));

  // R3
  hold_after_decode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != ST_IDLE) |=> ($stable(path_sel_o) && $stable(info_q) && $stable(path_sub_o)));

  // R2
  inactive_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_IDLE && !active) |=> (state_q == ST_IDLE));

  // R8
  quiet_states_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_IDLE || state_q == ST_WAIT) |-> (path_sel_o == '0 && !path_sub_o));
endmodule

// File: tb/spi_op_router_tb.sv
`timescale 1ns/1ps
module spi_op_router_tb;
  localparam int NS = 16;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] byte_i = '0;
  logic byte_vld = 1'b0;
  logic [1:0] mode = 2'd1;
  logic busy = 1'b0;
  logic [2:0] icpt = 3'b000;
  logic [NS*SW-1:0] cfg = '0;
  logic [6:0] sel;
  logic sub, ivld, iupl, itwo;
  logic [7:0] iopc;
  logic [1:0] ipipe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spi_op_router #(.NUM_SLOTS(NS)) u_dut (
    .clk_i(clk), .rst_i(rst), .byte_i(byte_i), .byte_vld_i(byte_vld),
    .spi_mode_i(mode), .busy_i(busy), .icpt_status_i(icpt[0]),
    .icpt_ident_i(icpt[1]), .icpt_param_i(icpt[2]), .slot_cfg_i(cfg),
    .path_sel_o(sel), .path_sub_o(sub), .info_vld_o(ivld),
    .info_opcode_o(iopc), .info_upload_o(iupl), .info_pipe_o(ipipe),
    .info_two_stage_o(itwo)
  );

  // {sel[7], sub, vld, opc[8], upl, pipe[2], two}
  function automatic logic [20:0] exp_f(input logic [NS*SW-1:0] c, input logic [7:0] b,
                                        input logic [1:0] m, input logic bsy, input logic [2:0] ic);
    logic [6:0] s = '0;
    logic sb = 1'b0;
    logic [11:0] si = '0;
    int k = -1;
    if (m != 2'd1 && m != 2'd2) return '0;
    for (int i = NS - 1; i >= 0; i--) begin
      logic [11:0] t = c[i*SW +: SW];
      bit gated = (i >= 5 && i <= 8) || (i >= 9 && t[2]);
      if (t[11] && t[10:3] == b && !(gated && bsy)) begin k = i; si = t; end
    end
    if (k < 0) return '0;
    if (k < 3)       begin if (m == 2'd1 || ic[0]) s[0] = 1'b1; end
    else if (k == 3) begin if (m == 2'd1 || ic[1]) s[1] = 1'b1; end
    else if (k == 4) begin if (m == 2'd1 || ic[2]) s[2] = 1'b1; end
    else if (k <= 6) begin s[5] = 1'b1; sb = (k == 5); end
    else if (k <= 8) begin s[6] = 1'b1; sb = (k == 7); end
    else if (si[2])  s[4] = 1'b1;
    else             s[3] = 1'b1;
    return {s, sb, si, (si[1:0] == 2'd1 || si[1:0] == 2'd2)};
  endfunction

  task automatic check(input logic [20:0] exp, input string tag);
    logic [20:0] act = {sel, sub, ivld, iopc, iupl, ipipe, itwo};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; byte_vld = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_i = b; byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic set_slot(input int i, input logic v, input logic [7:0] o,
                          input logic u, input logic [1:0] p);
    cfg[i*SW +: SW] = {v, o, u, p};
  endtask

  // full transaction: reset, first byte decoded, second byte ignored
  task automatic txn(input logic [1:0] m, input logic bsy, input logic [2:0] ic,
                     input logic [7:0] b, input string tag);
    logic [20:0] e;
    do_reset();
    mode = m; busy = bsy; icpt = ic;
    e = exp_f(cfg, b, m, bsy, ic);
    send(b);
    check(e, tag);
    busy = ~bsy; icpt = ~ic;
    send(b ^ 8'h01);
    check(e, {tag, " R3 hold"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check('0, "R1 reset state");

    set_slot(0, 1, 8'h05, 0, 0);
    set_slot(3, 1, 8'h9F, 0, 0);
    set_slot(4, 1, 8'h5A, 0, 0);
    set_slot(5, 1, 8'hB7, 0, 0);
    set_slot(6, 1, 8'hE9, 0, 0);
    set_slot(7, 1, 8'h06, 0, 0);
    set_slot(8, 1, 8'h04, 0, 0);
    set_slot(9, 1, 8'h03, 0, 2'd2);
    set_slot(10, 1, 8'h02, 1, 0);
    set_slot(12, 1, 8'h03, 0, 2'd0);

    txn(2'd1, 0, 3'b000, 8'h9F, "R5 ident flash");
    check({7'b0000010, 1'b0, 12'h000 | {1'b1, 8'h9F, 1'b0, 2'd0}, 1'b0}, "R5 ident flash literal");
    txn(2'd2, 0, 3'b000, 8'h9F, "R5 ident passthrough no intercept");
    txn(2'd2, 0, 3'b010, 8'h9F, "R5 ident passthrough intercept");
    txn(2'd2, 0, 3'b000, 8'h05, "R5 status passthrough");
    txn(2'd1, 0, 3'b000, 8'h5A, "R5 param flash");
    txn(2'd1, 0, 3'b000, 8'h03, "R4 R9 lowest slot two-stage");
    check({7'b0001000, 1'b0, 1'b1, 8'h03, 1'b0, 2'd2, 1'b1}, "R9 literal");
    txn(2'd1, 1, 3'b000, 8'hB7, "R6 enter4b busy");
    txn(2'd1, 0, 3'b000, 8'hB7, "R6 enter4b");
    txn(2'd1, 0, 3'b000, 8'hE9, "R6 exit4b");
    txn(2'd2, 0, 3'b000, 8'h06, "R6 write enable");
    txn(2'd1, 0, 3'b000, 8'h04, "R6 write disable");
    txn(2'd1, 1, 3'b000, 8'h02, "R7 upload busy");
    txn(2'd1, 0, 3'b000, 8'h02, "R7 upload");
    txn(2'd1, 0, 3'b000, 8'h77, "R8 no match");

    // R2: inactive mode ignores a byte, then active mode decodes
    do_reset();
    mode = 2'd0; busy = 1'b0; icpt = '0;
    send(8'h9F);
    check('0, "R2 mode0 ignored");
    mode = 2'd3;
    send(8'h9F);
    check('0, "R2 mode3 ignored");
    mode = 2'd1;
    send(8'h9F);
    check(exp_f(cfg, 8'h9F, 2'd1, 1'b0, 3'b000), "R2 decode after inactive");

    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        for (int i = 0; i < NS; i++)
          set_slot(i, 1'($urandom_range(0, 3) != 0), 8'($urandom_range(0, 7)),
                   1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
      end
      txn(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
          8'($urandom_range(0, 8)), "R4 R10 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule